// File: doc/BRIEF.md
# Self-Synchronizing Register State File

This block is the register file of a multithreaded integer core in which each register carries a two-bit synchronization tag beside its 32-bit value. The tag records whether the value is absent, whether a memory load has been issued to produce it, whether a thread has already tried to consume it, or whether it is present. A pipeline read of a register whose tag is not "full" returns no data. Instead it raises a switch request so the thread scheduler can park the reading thread and run another one.

The pipeline uses two combinational read ports and one write port. A load-issue port tags a destination register as awaiting memory. A fill port carries the data returned when a data cache line arrives, and the block writes it into the register that was awaiting it. If a thread had already stalled on that register, the block emits a registered wake pulse carrying the register index. The scheduler uses that pulse to make the parked thread runnable again.

Top module: `rsf_regfile`

## Requirements
- R1: After reset every register is empty (tag 00); an enabled read of any register returns hit=0, data 0 and raises `switch_o`, and `wake_o` is 0.
- R2: A pipeline write stores the data and sets the tag to full (11) at the clock edge; a later enabled read of that register gives hit=1, the written data and no switch.
- R3: A load issue sets the register's tag to pending (01) at the clock edge; an enabled read of a pending register gives hit=0, data 0 and raises `switch_o`.
- R4: A read of a pending register moves its tag to waiting (10) at the edge. A read of an empty or waiting register leaves its tag unchanged.
- R5: `switch_o` is 1 exactly when at least one enabled read port addresses a register that is not full. A disabled port never raises it and always returns hit=0 and data 0.
- R6: A fill to a pending or waiting register stores the fill data and sets the tag to full.
- R7: A fill to a waiting register produces `wake_o`=1 with `wake_idx_o` equal to the fill index in the cycle after the fill edge. A fill to a pending register that nobody read produces no wake.
- R8: A fill to a pending register that is being read in the same cycle sets it full and also produces the wake pulse of R7.
- R9: A fill to an empty or full register is ignored: data and tag are unchanged and no wake is produced.
- R10: A load issue and a write to the same register in the same cycle leave the tag pending.
- R11: A write and a fill to the same pending register in the same cycle leave the tag full with the write data.
- R12: The two read ports are independent and may address the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_en | input | 1 | Read port A enable |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, 0 unless hit |
| rd_a_hit | output | 1 | Read port A found a full register |
| rd_b_en | input | 1 | Read port B enable |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, 0 unless hit |
| rd_b_hit | output | 1 | Read port B found a full register |
| switch_o | output | 1 | Context switch request on a non-full read |
| wr_en | input | 1 | Pipeline write enable |
| wr_idx | input | 5 | Pipeline write index |
| wr_data | input | 32 | Pipeline write data |
| ld_en | input | 1 | Load issue enable |
| ld_idx | input | 5 | Load destination index |
| fill_en | input | 1 | Load data return enable |
| fill_idx | input | 5 | Load data return index |
| fill_data | input | 32 | Returned load data |
| wake_o | output | 1 | Registered wake pulse |
| wake_idx_o | output | 5 | Index of the woken register |

## Verification
The hazardous coincidence is a fill arriving in the same cycle as a read of the still-pending register it completes. The fill must win the tag, and the wake must not be lost even though the tag never showed waiting. The bench provokes this by issuing a load and then driving a read and a fill to that register in one cycle. It judges the result on three things: the read sees a switch, the next cycle carries a wake with the right index, and a following read hits with the fill data. Write-versus-load and write-versus-fill collisions on one index are provoked the same way and judged by the tag seen at a later read.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    RS_EMPTY = 2'b00,
    RS_PEND  = 2'b01,
    RS_WAIT  = 2'b10,
    RS_FULL  = 2'b11
  } rs_state_e;
endpackage

// File: rtl/rsf_entry.sv
module rsf_entry
  import rsf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              ld_hit,
  input  logic              fill_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] fill_data,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wake_req_o
);

  rs_state_e         state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              fill_ok;

  // a fill only lands on a register that is awaiting memory
  assign fill_ok = fill_hit && ((state_q == RS_PEND) || (state_q == RS_WAIT));

  always_comb begin
    state_d = state_q;
    if (ld_hit) begin
      state_d = RS_PEND;
    end else if (wr_hit || fill_ok) begin
      state_d = RS_FULL;
    end else if (rd_hit && (state_q == RS_PEND)) begin
      state_d = RS_WAIT;
    end
  end

  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (wr_hit) begin
      data_en = 1'b1;
      data_d  = wr_data;
    end else if (fill_ok && !ld_hit) begin
      data_en = 1'b1;
      data_d  = fill_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      data_q <= data_d;
    end
  end

  assign full_o     = (state_q == RS_FULL);
  assign data_o     = data_q;
  assign wake_req_o = fill_ok && ((state_q == RS_WAIT) || rd_hit);

  AST_WRITE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !ld_hit) |=> (state_q == RS_FULL)); // R2
  AST_LOAD_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |=> (state_q == RS_PEND)); // R3
  AST_READ_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RS_PEND) && rd_hit && !ld_hit && !wr_hit && !fill_hit) |=> (state_q == RS_WAIT)); // R4
  AST_FILL_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RS_EMPTY) && fill_hit && !ld_hit && !wr_hit) |=> (state_q == RS_EMPTY)); // R9
  AST_FILL_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RS_FULL) && fill_hit && !ld_hit && !wr_hit) |=> ((state_q == RS_FULL) && $stable(data_q))); // R9

endmodule

// File: rtl/rsf_read_port.sv
module rsf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [NUM_REGS-1:0] full_vec,
  input  logic [DATA_W-1:0]   data_arr [NUM_REGS],
  output logic                hit,
  output logic                miss,
  output logic [DATA_W-1:0]   data
);

  logic sel_full;

  assign sel_full = full_vec[idx];
  assign hit      = en && sel_full;
  assign miss     = en && !sel_full;
  assign data     = hit ? data_arr[idx] : '0;

endmodule

// File: rtl/rsf_wake.sv
module rsf_wake #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] wake_req,
  output logic                wake_o,
  output logic [IDX_W-1:0]    wake_idx_o
);

  logic             any_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    any_d = |wake_req;
    idx_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wake_req[i]) begin
        idx_d = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_o     <= 1'b0;
      wake_idx_o <= '0;
    end else begin
      wake_o <= any_d;
      if (any_d) begin
        wake_idx_o <= idx_d;
      end
    end
  end

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_req)); // R7

endmodule

// File: rtl/rsf_regfile.sv
module rsf_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int NPORTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_a_en,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_hit,
  input  logic              rd_b_en,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_hit,
  output logic              switch_o,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wake_o,
  output logic [IDX_W-1:0]  wake_idx_o
);

  logic [NUM_REGS-1:0] full_vec;
  logic [NUM_REGS-1:0] wake_req;
  logic [DATA_W-1:0]   data_arr [NUM_REGS];

  logic                p_en   [NPORTS];
  logic [IDX_W-1:0]    p_idx  [NPORTS];
  logic                p_hit  [NPORTS];
  logic                p_miss [NPORTS];
  logic [DATA_W-1:0]   p_data [NPORTS];

  assign p_en[0]  = rd_a_en;
  assign p_idx[0] = rd_a_idx;
  assign p_en[1]  = rd_b_en;
  assign p_idx[1] = rd_b_idx;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic rd_any;
      always_comb begin
        rd_any = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
          if (p_en[p] && (p_idx[p] == IDX_W'(g))) begin
            rd_any = 1'b1;
          end
        end
      end

      rsf_entry #(.DATA_W(DATA_W)) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_en   && (wr_idx   == IDX_W'(g))),
        .ld_hit     (ld_en   && (ld_idx   == IDX_W'(g))),
        .fill_hit   (fill_en && (fill_idx == IDX_W'(g))),
        .rd_hit     (rd_any),
        .wr_data    (wr_data),
        .fill_data  (fill_data),
        .full_o     (full_vec[g]),
        .data_o     (data_arr[g]),
        .wake_req_o (wake_req[g])
      );
    end

    for (g = 0; g < NPORTS; g++) begin : g_port
      rsf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
        .en       (p_en[g]),
        .idx      (p_idx[g]),
        .full_vec (full_vec),
        .data_arr (data_arr),
        .hit      (p_hit[g]),
        .miss     (p_miss[g]),
        .data     (p_data[g])
      );
    end
  endgenerate

  assign rd_a_hit  = p_hit[0];
  assign rd_a_data = p_data[0];
  assign rd_b_hit  = p_hit[1];
  assign rd_b_data = p_data[1];
  assign switch_o  = p_miss[0] || p_miss[1];

  rsf_wake #(.NUM_REGS(NUM_REGS)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_req   (wake_req),
    .wake_o     (wake_o),
    .wake_idx_o (wake_idx_o)
  );

  AST_WAKE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(fill_en) && (wake_idx_o == $past(fill_idx)))); // R7
  AST_HIT_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_hit && (rd_b_hit || !rd_b_en)) |-> !switch_o); // R5
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_a_hit && switch_o && !rd_b_en)); // R5

endmodule

// File: tb/rsf_regfile_tb_top.sv
module rsf_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_a_en, rd_b_en, wr_en, ld_en, fill_en;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, ld_idx, fill_idx;
  logic [31:0] wr_data, fill_data;
  logic [31:0] rd_a_data, rd_b_data;
  logic        rd_a_hit, rd_b_hit, switch_o, wake_o;
  logic [4:0]  wake_idx_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  rsf_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_hit(rd_a_hit),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_hit(rd_b_hit),
    .switch_o(switch_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_en(ld_en), .ld_idx(ld_idx),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data),
    .wake_o(wake_o), .wake_idx_o(wake_idx_o)
  );

  // [75]wr [74]ld [73]fill [72]rd [71:67]idx [66:35]data [34]sw [33]hit [32]wake [31:0]rdata
  localparam int NV = 20;
  localparam logic [75:0] VEC [NV] = '{
    {4'b0001, 5'd3, 32'h0,         3'b100, 32'h0},         // R1 empty read
    {4'b1000, 5'd3, 32'hA5A5_0001, 3'b000, 32'h0},         // R2 write
    {4'b0001, 5'd3, 32'h0,         3'b010, 32'hA5A5_0001}, // R2 read back
    {4'b0100, 5'd3, 32'h0,         3'b000, 32'h0},         // R3 load issue
    {4'b0001, 5'd3, 32'h0,         3'b100, 32'h0},         // R3 pending read
    {4'b0001, 5'd3, 32'h0,         3'b100, 32'h0},         // R4 waiting read
    {4'b0010, 5'd3, 32'h1234_5678, 3'b001, 32'h0},         // R7 fill waiting
    {4'b0001, 5'd3, 32'h0,         3'b010, 32'h1234_5678}, // R6 read filled
    {4'b0100, 5'd4, 32'h0,         3'b000, 32'h0},         // R3 load
    {4'b0010, 5'd4, 32'hCAFE_0004, 3'b000, 32'h0},         // R7 fill pending, no wake
    {4'b0001, 5'd4, 32'h0,         3'b010, 32'hCAFE_0004}, // R6
    {4'b0010, 5'd5, 32'h0000_DEAD, 3'b000, 32'h0},         // R9 fill empty
    {4'b0001, 5'd5, 32'h0,         3'b100, 32'h0},         // R9 still empty
    {4'b0010, 5'd3, 32'h0000_BEEF, 3'b000, 32'h0},         // R9 fill full
    {4'b0001, 5'd3, 32'h0,         3'b010, 32'h1234_5678}, // R9 unchanged
    {4'b0100, 5'd6, 32'h0,         3'b000, 32'h0},         // R8 load
    {4'b0011, 5'd6, 32'h0000_0066, 3'b101, 32'h0},         // R8 fill + read
    {4'b0001, 5'd6, 32'h0,         3'b010, 32'h0000_0066}, // R8
    {4'b1100, 5'd7, 32'h0000_0077, 3'b000, 32'h0},         // R10 write + load
    {4'b0001, 5'd7, 32'h0,         3'b100, 32'h0}          // R10 pending
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_a_en = 0; rd_b_en = 0; wr_en = 0; ld_en = 0; fill_en = 0;
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; ld_idx = 0; fill_idx = 0;
    wr_data = 0; fill_data = 0;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(wake_o == 1'b0, "R1 wake in reset", {31'b0, wake_o}, 32'h0);
    check(switch_o == 1'b0, "R1 idle switch", {31'b0, switch_o}, 32'h0);
    rd_a_en = 1; rd_a_idx = 5'd31; #1;
    check(switch_o && !rd_a_hit && rd_a_data == 0, "R1 empty after reset", {30'b0, switch_o, rd_a_hit}, 32'h2);
    idle();
    rst_n = 1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      logic [75:0] e;
      e = VEC[v];
      idle();
      wr_en = e[75]; ld_en = e[74]; fill_en = e[73]; rd_a_en = e[72];
      wr_idx = e[71:67]; ld_idx = e[71:67]; fill_idx = e[71:67]; rd_a_idx = e[71:67];
      wr_data = e[66:35]; fill_data = e[66:35];
      #1;
      check(switch_o == e[34], $sformatf("R5 switch vec %0d", v), {31'b0, switch_o}, {31'b0, e[34]});
      check(rd_a_hit == e[33], $sformatf("R2 hit vec %0d", v), {31'b0, rd_a_hit}, {31'b0, e[33]});
      check(rd_a_data == e[31:0], $sformatf("R6 data vec %0d", v), rd_a_data, e[31:0]);
      @(posedge clk); #1;
      check(wake_o == e[32], $sformatf("R7 wake vec %0d", v), {31'b0, wake_o}, {31'b0, e[32]});
      if (e[32]) begin
        check(wake_idx_o == e[71:67], $sformatf("R7 wake idx vec %0d", v), {27'b0, wake_idx_o}, {27'b0, e[71:67]});
      end
    end

    // R11: write and fill on one pending register
    idle(); ld_en = 1; ld_idx = 5'd9;
    @(posedge clk); #1;
    idle(); wr_en = 1; wr_idx = 5'd9; wr_data = 32'h0000_0111;
    fill_en = 1; fill_idx = 5'd9; fill_data = 32'h0000_0222;
    @(posedge clk); #1;
    idle(); rd_a_en = 1; rd_a_idx = 5'd9; #1;
    check(rd_a_hit && rd_a_data == 32'h111, "R11 write beats fill", rd_a_data, 32'h111);

    // R12 and R5: two ports, one hit one miss, then same index
    idle(); rd_a_en = 1; rd_a_idx = 5'd5; rd_b_en = 1; rd_b_idx = 5'd3; #1;
    check(rd_b_hit && rd_b_data == 32'h1234_5678, "R12 port B hit", rd_b_data, 32'h1234_5678);
    check(!rd_a_hit && switch_o, "R5 miss on A sets switch", {31'b0, switch_o}, 32'h1);
    rd_a_idx = 5'd3; #1;
    check(rd_a_hit && rd_b_hit && rd_a_data == rd_b_data && !switch_o, "R12 same index", rd_a_data, 32'h1234_5678);
    // R5: disabled port on empty register raises nothing
    rd_a_en = 0; rd_a_idx = 5'd20; rd_b_en = 0; #1;
    check(!switch_o && !rd_a_hit && rd_a_data == 0, "R5 disabled port", {31'b0, switch_o}, 32'h0);
    // R4: read of empty leaves it empty, so a later fill stays ignored
    rd_a_en = 1; @(posedge clk); #1;
    idle(); fill_en = 1; fill_idx = 5'd20; fill_data = 32'h55;
    @(posedge clk); #1;
    check(!wake_o, "R4 empty read no wait", {31'b0, wake_o}, 32'h0);
    idle(); rd_a_en = 1; rd_a_idx = 5'd20; #1;
    check(switch_o && !rd_a_hit, "R4 empty stays empty", {31'b0, switch_o}, 32'h1);
    idle();
    @(posedge clk); #1;
    finish_run();
  end

endmodule